// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block sits between a processor core's external bus controller and an outside bus master that wants to borrow the external bus for a while. The outside master pulls an active-low hold request. Once the core's current external cycle has ended, the block answers with an active-low hold acknowledge and switches off the core's bus drivers. The core is not frozen during this time. It keeps running from on-chip resources, and it stalls only when it actually asks for an external cycle.

When the core asks for the bus while the bus is lent out, the block pulls an active-low bus-request line toward the outside master. It also raises a flag that masks every interrupt source, the non-maskable one included, until the bus comes back. After the hold request is seen released, the block keeps the acknowledge low for exactly one more clock. On the next edge it drops the acknowledge, withdraws the bus request, turns the drivers back on and grants the waiting core request, all on that one edge.

The hold request input comes from outside the chip, so it passes through a synchronizer whose depth is a parameter. A depth of zero means the input is already synchronous.

Top module: `bus_hold_arbiter`

## Requirements
- R1: Reset is asynchronous and active low. It immediately puts the block in the owned state: hold_ack_n=1, bus_req_n=1, drv_en=1, irq_block=0. It does not wait for hold_req_n to go high, and the synchronizer restarts from "no request".
- R2: hold_req_n is taken through SYNC_STAGES flip-flops (default 2) before it is acted on. An acknowledged hold is entered only on an edge where cyc_busy is 0. On that edge hold_ack_n falls and drv_en falls together.
- R3: While the bus is lent out and core_req is 0, bus_req_n stays 1 and irq_block stays 0.
- R4: A core_req of 1 while the bus is lent out drives bus_req_n to 0 on the next edge. bus_req_n stays 0 until the release edge of R6.
- R5: irq_block is 1 exactly while bus_req_n is 0, in the waiting states and the release state that follows them.
- R6: On the first edge where the synchronized hold request reads released, the block enters a one-clock release state with hold_ack_n still 0. On the next edge hold_ack_n rises, drv_en rises, and a pending core_req is granted (core_gnt=1) in that same cycle.
- R7: bus_req_n rises on the same edge as hold_ack_n.
- R8: A hold that ends with no core request is released with the same one-clock delay, and bus_req_n never falls.
- R9: On an edge where the synchronized hold request is active and cyc_busy is 0, the hold wins over a simultaneous core_req. core_gnt is 0 in that cycle and in every state other than the owned state.
- R10: In the owned state, with no hold being taken, core_gnt follows core_req combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one clock is one state time |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Active-low bus hold request from the outside master |
| hold_ack_n | output | 1 | Active-low hold acknowledge to the outside master |
| bus_req_n | output | 1 | Active-low request to the outside master to hand the bus back |
| core_req | input | 1 | Core needs an external memory or data cycle |
| cyc_busy | input | 1 | An external bus cycle of the core is in progress |
| core_gnt | output | 1 | Core may start its external cycle |
| drv_en | output | 1 | Enable for the core's address, data and strobe drivers |
| irq_block | output | 1 | Masks interrupt acceptance, NMI included |

## Verification
The hardest situation to reach is a hold request that becomes active while an external cycle is still in flight and a new core request arrives at the same boundary. The hold must wait out the cycle and then win the boundary. The bench gets there by holding cyc_busy high with core_req asserted while the hold request ripples through the synchronizer. It then drops cyc_busy with core_req still high and checks that the grant disappears and that the bus request appears one edge later. A second hard case is the exact release timing. For that, the bench counts the synchronizer stages by hand and checks the acknowledge on each edge from the deassertion of the hold request to the return of the bus.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
   typedef enum logic [2:0] {
      ST_OWN      = 3'd0,
      ST_LENT     = 3'd1,
      ST_WAIT     = 3'd2,
      ST_REL_IDLE = 3'd3,
      ST_REL_WAIT = 3'd4
   } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_n
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_depth
      $error("hold_sync: STAGES must be within 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign sync_n = async_n;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh[0] <= 1'b1;
         else        sh[0] <= async_n;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b1;
            else        sh[i] <= sh[i-1];
         end
      end
      assign sync_n = sh[STAGES-1];
   end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
   import bus_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold_on,
   input  logic core_req,
   input  logic cyc_busy,
   output logic hold_ack_n,
   output logic bus_req_n,
   output logic core_gnt,
   output logic drv_en,
   output logic irq_block
);
   hold_state_e state, state_nx;
   logic        take_hold;

   assign take_hold = hold_on && !cyc_busy;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_OWN:      if (take_hold) state_nx = ST_LENT;
         ST_LENT:     if (!hold_on)  state_nx = ST_REL_IDLE;
                      else if (core_req) state_nx = ST_WAIT;
         ST_WAIT:     if (!hold_on)  state_nx = ST_REL_WAIT;
         ST_REL_IDLE: state_nx = ST_OWN;
         ST_REL_WAIT: state_nx = ST_OWN;
         default:     state_nx = ST_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OWN;
      else        state <= state_nx;
   end

   logic waiting;
   assign waiting    = (state == ST_WAIT) || (state == ST_REL_WAIT);
   assign drv_en     = (state == ST_OWN);
   assign hold_ack_n = (state == ST_OWN);
   assign bus_req_n  = !waiting;
   assign irq_block  = waiting;
   assign core_gnt   = (state == ST_OWN) && core_req && !take_hold;

   // R2: acknowledge only after the in-flight cycle has ended
   assert_ack_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_ack_n) |-> $past(!cyc_busy));
   // R4: bus request appears only in answer to a core request
   assert_breq_on_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req_n) |-> $past(core_req) && !hold_ack_n);
   // R5: interrupt masking starts only because the core asked for the bus
   assert_irq_block_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_block) |-> $past(core_req && !hold_ack_n));
   // R6: release only after the synchronized request was seen gone
   assert_release_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack_n) |-> $past(!hold_on) && drv_en);
   // R7: bus request withdrawn on the acknowledge release edge
   assert_breq_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req_n) |-> $rose(hold_ack_n));
   // R9: no grant while the bus is lent out
   assert_no_grant_lent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      core_gnt |-> hold_ack_n && drv_en);
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_req_n,
   output logic hold_ack_n,
   output logic bus_req_n,
   input  logic core_req,
   input  logic cyc_busy,
   output logic core_gnt,
   output logic drv_en,
   output logic irq_block
);
   logic hold_sync_n;

   hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (hold_req_n),
      .sync_n  (hold_sync_n)
   );

   hold_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_on    (!hold_sync_n),
      .core_req   (core_req),
      .cyc_busy   (cyc_busy),
      .hold_ack_n (hold_ack_n),
      .bus_req_n  (bus_req_n),
      .core_gnt   (core_gnt),
      .drv_en     (drv_en),
      .irq_block  (irq_block)
   );
endmodule

// File: tb/bus_hold_arbiter_tb.sv
`timescale 1ns/1ps
module bus_hold_arbiter_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_req_n = 1'b1;
   logic core_req = 1'b0;
   logic cyc_busy = 1'b0;
   logic hold_ack_n, bus_req_n, core_gnt, drv_en, irq_block;
   int   checks = 0;
   int   errors = 0;

   always #2.5 clk = ~clk;

   bus_hold_arbiter #(.SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
      .bus_req_n(bus_req_n), .core_req(core_req), .cyc_busy(cyc_busy),
      .core_gnt(core_gnt), .drv_en(drv_en), .irq_block(irq_block)
   );

   // {req tag, hold_req_n, core_req, cyc_busy | ack_n, breq_n, drv_en, gnt, irq_block}
   localparam int NV = 27;
   localparam logic [11:0] VEC [NV] = '{
      {4'd10, 8'b110_11110},  // R10 owned, grant follows request
      {4'd2,  8'b001_11100},  // R2 hold enters sync stage 1
      {4'd2,  8'b001_11100},  // R2 hold synchronized, cycle busy
      {4'd2,  8'b001_11100},  // R2 still busy: no acknowledge
      {4'd2,  8'b000_01000},  // R2 boundary: ack low, drivers off
      {4'd3,  8'b000_01000},  // R3 lent, no core request
      {4'd4,  8'b010_00001},  // R4 core asks: breq low, irq blocked
      {4'd5,  8'b110_00001},  // R5 hold released, sync stage 1
      {4'd4,  8'b110_00001},  // R4 still waiting
      {4'd6,  8'b110_00001},  // R6 release state, ack still low
      {4'd6,  8'b110_11110},  // R6 bus back, pending request granted
      {4'd7,  8'b100_11100},  // R7 breq stayed high after release
      {4'd8,  8'b000_11100},
      {4'd8,  8'b000_11100},
      {4'd8,  8'b000_01000},  // R8 lent without request
      {4'd8,  8'b100_01000},
      {4'd8,  8'b100_01000},
      {4'd8,  8'b100_01000},  // R8 release state, breq never low
      {4'd8,  8'b100_11100},  // R8 bus back
      {4'd9,  8'b011_11110},  // R9 busy cycle keeps grant
      {4'd9,  8'b011_11110},  // R9 hold synchronized but cycle busy
      {4'd9,  8'b010_01000},  // R9 hold wins the boundary
      {4'd4,  8'b010_00001},  // R4 request during hold
      {4'd5,  8'b110_00001},
      {4'd5,  8'b110_00001},
      {4'd7,  8'b110_00001},  // R7 release state keeps breq low
      {4'd6,  8'b110_11110}   // R6 R7 all released on one edge
   };

   task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: ack/breq/drv/gnt/irq got %b expected %b", tag, got, exp);
      end
   endtask

   function automatic logic [4:0] outs();
      return {hold_ack_n, bus_req_n, drv_en, core_gnt, irq_block};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state", outs(), 5'b11100);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         {hold_req_n, core_req, cyc_busy} = VEC[i][7:5];
         @(posedge clk);
         #1;
         check($sformatf("R%0d vector %0d", VEC[i][11:8], i), outs(), VEC[i][4:0]);
      end
      // R1: reset while waiting for the bus returns ownership at once
      hold_req_n = 1'b0; core_req = 1'b1; cyc_busy = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check("R4 waiting before reset", outs(), 5'b00001);
      rst_n = 1'b0;
      #1;
      check("R1 async reset while held", outs(), 5'b11110);
      core_req = 1'b0;
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 first edge after reset", outs(), 5'b11100);
      @(posedge clk);
      #1;
      check("R1 R2 synchronizer restarted", outs(), 5'b11100);
      @(posedge clk);
      #1;
      check("R2 hold taken again", outs(), 5'b01000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule